// File: doc/BRIEF.md
# Flash Access Guard

This block sits between a CPU bus and a paged non-volatile memory controller. It decides, one request at a time, whether an access to flash may proceed. Each request carries an address, a kind (code read or fetch, data write, page erase, data read), the address of the code that issued it, and a flag marking requests from the external debug port. Two software enable bits gate writes and erases. A stored lock byte defines a protected region that starts at page 0.

The number of locked pages is the one's complement of the lock byte, clamped to the number of pages in flash. The last page holds the lock byte. That page is locked as soon as any other page is locked. Code that runs from a locked page counts as protected and may touch locked pages. Debug-port requests never count as protected. The verdict is registered and appears one clock after the request. A granted write or erase emits a one-cycle command strobe toward the memory controller. Every denial sets a sticky violation flag, and software clears that flag by writing 1.

Top module: `flash_guard`

## Requirements
- R1: The grant or deny verdict is a one-cycle pulse in the clock after `reqValid` is high. Grant and deny are never high together, and neither is high without a request in the previous cycle.
- R2: With FLASH_BYTES=2048 and 512-byte pages, page k (addresses k*0x200 to k*0x200+0x1FF) is locked when k < n. n is the bitwise complement of `lockByte`, clamped to the page count: 0xFD gives n=2, 0xFE gives n=1, 0x00 locks every page.
- R3: The last page (0x600 to 0x7FF by default, holding the lock byte at 0x7FF) is locked exactly when `lockByte` is not 0xFF.
- R4: A code read, write or erase that targets a locked page is denied when `fromDebug` is 1, or when `pcAddr` lies in an unlocked page.
- R5: A request with `fromDebug`=0 and `pcAddr` in a locked page may access locked pages, subject to R6 and R7.
- R6: A data write (`reqType`=1) is granted only when `wrEn` is 1.
- R7: A page erase (`reqType`=2) is granted only when both `wrEn` and `erEn` are 1. A code read (`reqType`=0) needs neither enable bit.
- R8: A data read (`reqType`=3) goes to data RAM. It yields neither grant nor deny, no strobe, and leaves the violation flag unchanged.
- R9: Each denial sets `violFlag` in the same cycle that deny is asserted. The flag stays set until a cycle with `violClr`=1 and no new denial. A denial arriving together with a clear leaves the flag set.
- R10: A granted write pulses `wrStrobe` and a granted erase pulses `erStrobe`, each for one cycle aligned with grant. A denied request produces no strobe.
- R11: While `rstN` is low, every output is 0, including the violation flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqType | input | 2 | 0 code read, 1 data write, 2 page erase, 3 data read |
| reqAddr | input | ADDR_W | Flash byte address targeted |
| pcAddr | input | ADDR_W | Address of the code issuing the request |
| fromDebug | input | 1 | Request comes from the debug port |
| wrEn | input | 1 | Software write enable bit |
| erEn | input | 1 | Software erase enable bit |
| lockByte | input | 8 | Stored security lock byte |
| violClr | input | 1 | Write-1 clear of the violation flag |
| grantOut | output | 1 | Request granted (one cycle after request) |
| denyOut | output | 1 | Request denied (one cycle after request) |
| wrStrobe | output | 1 | Flash write command |
| erStrobe | output | 1 | Flash erase command |
| violFlag | output | 1 | Sticky denied-access flag |

## Verification
Every result (grant, deny, both strobes and the flag update) is due exactly one rising edge after the request is presented. The bench drives each request on a falling edge and drops `reqValid` on the next falling edge. It samples the outputs there, half a cycle after the registering edge. It then samples them once more a cycle later to confirm that each pulse lasts one cycle. A flag clear is checked the same way, one edge after `violClr`.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [1:0] {
    REQ_CODE_RD = 2'd0,
    REQ_DATA_WR = 2'd1,
    REQ_PAGE_ER = 2'd2,
    REQ_DATA_RD = 2'd3
  } reqKind_e;

  // Strobes the control logic hands to the datapath registers
  typedef struct packed {
    logic grant;
    logic deny;
    logic wrCmd;
    logic erCmd;
  } ctlStrobe_t;

endpackage

// File: rtl/flash_guard_dp.sv
module flash_guard_dp
  import flash_guard_pkg::*;
#(
  parameter int FLASH_BYTES = 2048,
  parameter int PAGE_BYTES  = 512,
  localparam int ADDR_W     = $clog2(FLASH_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] pcAddr,
  input  logic [7:0]        lockByte,
  input  logic              violClr,
  input  ctlStrobe_t        strobe,
  output logic              targetLocked,
  output logic              pcProtected,
  output logic              grantOut,
  output logic              denyOut,
  output logic              wrStrobe,
  output logic              erStrobe,
  output logic              violFlag
);

  localparam int OFS_W     = $clog2(PAGE_BYTES);
  localparam int PAGE_W    = ADDR_W - OFS_W;
  localparam int NUM_PAGES = FLASH_BYTES / PAGE_BYTES;
  localparam int LOCK_PAGE = NUM_PAGES - 1;

  logic [31:0]          rawCount;
  logic [31:0]          lockCount;
  logic                 anyLocked;
  logic [NUM_PAGES-1:0] pageLockVec;
  logic [PAGE_W-1:0]    reqPage;
  logic [PAGE_W-1:0]    pcPage;

  // Locked page count: complement of the lock byte, clamped to flash size
  assign rawCount  = 32'({1'b0, ~lockByte});
  assign lockCount = (rawCount > 32'(NUM_PAGES)) ? 32'(NUM_PAGES) : rawCount;
  assign anyLocked = (lockByte != 8'hFF);

  for (genvar pg = 0; pg < NUM_PAGES; pg++) begin : g_page
    if (pg == LOCK_PAGE) begin : g_lockPage
      assign pageLockVec[pg] = anyLocked || (32'(pg) < lockCount);
    end else begin : g_userPage
      assign pageLockVec[pg] = (32'(pg) < lockCount);
    end
  end

  assign reqPage      = reqAddr[ADDR_W-1:OFS_W];
  assign pcPage       = pcAddr[ADDR_W-1:OFS_W];
  assign targetLocked = pageLockVec[reqPage];
  assign pcProtected  = pageLockVec[pcPage];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantOut <= 1'b0;
      denyOut  <= 1'b0;
      wrStrobe <= 1'b0;
      erStrobe <= 1'b0;
      violFlag <= 1'b0;
    end else begin
      grantOut <= strobe.grant;
      denyOut  <= strobe.deny;
      wrStrobe <= strobe.wrCmd;
      erStrobe <= strobe.erCmd;
      violFlag <= strobe.deny | (violFlag & ~violClr);
    end
  end

  AST_DENY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    denyOut |-> violFlag); // R9

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(violClr) && !denyOut) |-> !violFlag); // R9

endmodule

// File: rtl/flash_guard_ctl.sv
module flash_guard_ctl
  import flash_guard_pkg::*;
(
  input  logic       reqValid,
  input  reqKind_e   reqKind,
  input  logic       fromDebug,
  input  logic       wrEn,
  input  logic       erEn,
  input  logic       targetLocked,
  input  logic       pcProtected,
  output ctlStrobe_t strobe
);

  logic pageAccess;
  logic enablesOk;
  logic isFlash;
  logic allow;

  assign pageAccess = !targetLocked || (pcProtected && !fromDebug);

  always_comb begin
    enablesOk = 1'b0;
    isFlash   = 1'b1;
    unique case (reqKind)
      REQ_CODE_RD: enablesOk = 1'b1;
      REQ_DATA_WR: enablesOk = wrEn;
      REQ_PAGE_ER: enablesOk = wrEn && erEn;
      REQ_DATA_RD: isFlash   = 1'b0;
      default:     isFlash   = 1'b0;
    endcase
  end

  assign allow = pageAccess && enablesOk;

  always_comb begin
    strobe.grant = reqValid && isFlash && allow;
    strobe.deny  = reqValid && isFlash && !allow;
    strobe.wrCmd = strobe.grant && (reqKind == REQ_DATA_WR);
    strobe.erCmd = strobe.grant && (reqKind == REQ_PAGE_ER);
  end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int FLASH_BYTES = 2048,
  parameter int PAGE_BYTES  = 512,
  localparam int ADDR_W     = $clog2(FLASH_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] pcAddr,
  input  logic              fromDebug,
  input  logic              wrEn,
  input  logic              erEn,
  input  logic [7:0]        lockByte,
  input  logic              violClr,
  output logic              grantOut,
  output logic              denyOut,
  output logic              wrStrobe,
  output logic              erStrobe,
  output logic              violFlag
);

  ctlStrobe_t strobe;
  logic       targetLocked;
  logic       pcProtected;

  flash_guard_ctl i_ctl (
    .reqValid     (reqValid),
    .reqKind      (reqKind_e'(reqType)),
    .fromDebug    (fromDebug),
    .wrEn         (wrEn),
    .erEn         (erEn),
    .targetLocked (targetLocked),
    .pcProtected  (pcProtected),
    .strobe       (strobe)
  );

  flash_guard_dp #(
    .FLASH_BYTES (FLASH_BYTES),
    .PAGE_BYTES  (PAGE_BYTES)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqAddr      (reqAddr),
    .pcAddr       (pcAddr),
    .lockByte     (lockByte),
    .violClr      (violClr),
    .strobe       (strobe),
    .targetLocked (targetLocked),
    .pcProtected  (pcProtected),
    .grantOut     (grantOut),
    .denyOut      (denyOut),
    .wrStrobe     (wrStrobe),
    .erStrobe     (erStrobe),
    .violFlag     (violFlag)
  );

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    !(grantOut && denyOut)); // R1

  AST_VERDICT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut || denyOut) |-> $past(reqValid)); // R1

  AST_WR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> ($past(wrEn) && $past(reqType) == 2'd1)); // R6

  AST_ER_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    erStrobe |-> ($past(wrEn) && $past(erEn))); // R7

  AST_DENY_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    denyOut |-> !(wrStrobe || erStrobe)); // R10

  AST_DATA_RD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid) && $past(reqType) == 2'd3) |-> !(grantOut || denyOut)); // R8

  AST_DEBUG_LOCKED_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && fromDebug && reqType != 2'd3 && lockByte == 8'h00) |=> denyOut); // R4

endmodule

// File: tb/test_flash_guard.sv
`timescale 1ns/1ps
module test_flash_guard;

  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqType = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [AW-1:0] pcAddr = '0;
  logic          fromDebug = 1'b0;
  logic          wrEn = 1'b0;
  logic          erEn = 1'b0;
  logic [7:0]    lockByte = 8'hFF;
  logic          violClr = 1'b0;
  logic          grantOut, denyOut, wrStrobe, erStrobe, violFlag;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  flash_guard i_flash_guard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqAddr(reqAddr), .pcAddr(pcAddr), .fromDebug(fromDebug),
    .wrEn(wrEn), .erEn(erEn), .lockByte(lockByte), .violClr(violClr),
    .grantOut(grantOut), .denyOut(denyOut), .wrStrobe(wrStrobe),
    .erStrobe(erStrobe), .violFlag(violFlag)
  );

  typedef struct packed {
    logic [1:0]    kind;
    logic [AW-1:0] addr;
    logic [AW-1:0] pc;
    logic          dbg;
    logic          we;
    logic          ee;
    logic [7:0]    lock;
    logic [3:0]    expOut;  // {grant, deny, wrStrobe, erStrobe}
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 11'h100, 11'h500, 1'b0, 1'b0, 1'b0, 8'hFD, 4'b0100, 4'd4},  // R4 outside code reads locked page 0
    '{2'd0, 11'h100, 11'h050, 1'b0, 1'b0, 1'b0, 8'hFD, 4'b1000, 4'd5},  // R5 protected code reads page 0
    '{2'd0, 11'h450, 11'h500, 1'b0, 1'b0, 1'b0, 8'hFD, 4'b1000, 4'd2},  // R2 page 2 unlocked
    '{2'd0, 11'h7FF, 11'h500, 1'b0, 1'b0, 1'b0, 8'hFD, 4'b0100, 4'd3},  // R3 lock page locked
    '{2'd0, 11'h7FF, 11'h500, 1'b0, 1'b0, 1'b0, 8'hFF, 4'b1000, 4'd3},  // R3 lock page open at 0xFF
    '{2'd1, 11'h450, 11'h500, 1'b0, 1'b0, 1'b0, 8'hFD, 4'b0100, 4'd6},  // R6 write without enable
    '{2'd1, 11'h450, 11'h500, 1'b0, 1'b1, 1'b0, 8'hFD, 4'b1010, 4'd6},  // R6 write enabled
    '{2'd2, 11'h450, 11'h500, 1'b0, 1'b1, 1'b0, 8'hFD, 4'b0100, 4'd7},  // R7 erase missing erEn
    '{2'd2, 11'h450, 11'h500, 1'b0, 1'b0, 1'b1, 8'hFD, 4'b0100, 4'd7},  // R7 erase missing wrEn
    '{2'd2, 11'h450, 11'h500, 1'b0, 1'b1, 1'b1, 8'hFD, 4'b1001, 4'd7},  // R7 erase enabled
    '{2'd1, 11'h200, 11'h010, 1'b1, 1'b1, 1'b0, 8'hFD, 4'b0100, 4'd4},  // R4 debug write to locked page
    '{2'd2, 11'h000, 11'h300, 1'b0, 1'b1, 1'b1, 8'hFD, 4'b1001, 4'd5},  // R5 protected erase of page 0
    '{2'd0, 11'h400, 11'h000, 1'b1, 1'b0, 1'b0, 8'h00, 4'b0100, 4'd2},  // R2 clamp locks every page
    '{2'd0, 11'h200, 11'h400, 1'b0, 1'b0, 1'b0, 8'hFE, 4'b1000, 4'd2},  // R2 n=1 leaves page 1 open
    '{2'd0, 11'h000, 11'h400, 1'b0, 1'b0, 1'b0, 8'hFE, 4'b0100, 4'd2},  // R2 n=1 locks page 0
    '{2'd3, 11'h000, 11'h400, 1'b1, 1'b1, 1'b1, 8'h00, 4'b0000, 4'd8}   // R8 data read stays silent
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic request(input vec_t v, input logic clr);
    @(negedge clk);
    reqType = v.kind; reqAddr = v.addr; pcAddr = v.pc; fromDebug = v.dbg;
    wrEn = v.we; erEn = v.ee; lockByte = v.lock; reqValid = 1'b1; violClr = clr;
    @(negedge clk);
    reqValid = 1'b0; violClr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R11 reset state with a request pending
    reqValid = 1'b1; reqType = 2'd1; wrEn = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 outputs in reset", {grantOut, denyOut, wrStrobe, erStrobe, violFlag}, 0);
    reqValid = 1'b0; wrEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle no verdict", {grantOut, denyOut}, 0);

    for (int i = 0; i < NV; i++) begin
      request(VECS[i], 1'b0);
      check($sformatf("R%0d vector %0d verdict", VECS[i].req, i),
            {grantOut, denyOut, wrStrobe, erStrobe}, VECS[i].expOut);
      if (VECS[i].expOut[2]) check($sformatf("R9 flag after deny %0d", i), violFlag, 1);
      @(negedge clk);
      check($sformatf("R1 pulse ends %0d", i), {grantOut, denyOut, wrStrobe, erStrobe}, 0);
    end

    // R9 clear, then hold, then set wins over clear
    @(negedge clk); violClr = 1'b1;
    @(negedge clk); violClr = 1'b0;
    check("R9 flag cleared", violFlag, 0);
    request(VECS[2], 1'b0);
    check("R9 grant leaves flag clear", violFlag, 0);
    request(VECS[0], 1'b1);
    check("R9 deny beats clear", violFlag, 1);
    repeat (3) @(negedge clk);
    check("R9 flag holds", violFlag, 1);

    // R8 data read does not disturb the flag
    request(VECS[15], 1'b0);
    check("R8 flag unchanged", violFlag, 1);

    // R10 write to locked page from outside code gives no strobe
    request('{2'd1, 11'h7F0, 11'h400, 1'b0, 1'b1, 1'b1, 8'hFD, 4'b0100, 4'd10}, 1'b0);
    check("R10 denied write no strobe", {denyOut, wrStrobe, erStrobe}, 3'b100);

    // R11 mid-run reset clears the flag
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R11 flag cleared by reset", violFlag, 0);
    rstN = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule